// File: doc/BRIEF.md
# Cache-Allocate Store Backup Buffer

This block keeps a copy of every store made by a cache-allocating store instruction. A later line invalidate then writes the saved data back to memory instead of losing it. Each recorded store holds its full address and data word, and stores are kept in the order they arrived. A store whose cacheable flag is low is not recorded.

An invalidate command carries an address and is compared with the stored entries on the 32-byte line, so the low five address bits are not used. The oldest matching entry is moved into a write holding register and removed from the buffer. It then goes out on a single-beat memory write port that uses a valid/ready handshake. Only one entry leaves per command. The entries behind it shift forward and keep their order. A discard strobe empties the whole buffer and produces no memory traffic.

Top module: `cas_backup_buf`

## Requirements
- R1: After reset the buffer is empty, and `full`, `mem_wr_valid`, `inv_done` and `overflow` are all low. An invalidate issued at this point is a miss.
- R2: A record request with `rec_cacheable` low is ignored. A later invalidate to that line finds no entry.
- R3: Entries are kept in arrival order. An invalidate picks the oldest valid entry on the line and writes out its full stored address.
- R4: The line compare uses address bits [31:5] only. Addresses that differ only in bits [4:0] match, and a difference in bit 5 or above does not match.
- R5: On a hit, `mem_wr_valid` rises one cycle after the command, carrying the entry's stored address and data. Both stay stable until `mem_wr_ready` is sampled high.
- R6: Each invalidate removes at most one entry, even when several entries share the line. The remaining entries keep their relative order.
- R7: On a miss there is no memory write, and `inv_done` pulses for one cycle in the cycle after the command.
- R8: On a hit, `inv_done` pulses for one cycle in the cycle after the write is accepted (`mem_wr_valid` and `mem_wr_ready` both high). In that same cycle `mem_wr_valid` falls.
- R9: `discard` clears every entry and starts no write. A record in the same cycle is dropped. An invalidate in the same cycle is treated as a miss.
- R10: `full` is high while DEPTH entries are held. A cacheable record made while `full` is high is dropped, and `overflow` pulses in the next cycle.
- R11: An invalidate issued while a write is pending is ignored. It produces no `inv_done` and removes no entry.
- R12: A record and an invalidate removal in the same cycle both take effect. The new entry lands behind the surviving entries. The full test uses the count before the removal, so a record to a full buffer is still dropped in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Record request strobe |
| rec_addr | input | 32 | Store address to record |
| rec_data | input | 32 | Store data to record |
| rec_cacheable | input | 1 | Store address is cacheable |
| inv_valid | input | 1 | Line invalidate command strobe |
| inv_addr | input | 32 | Invalidate address (bits [4:0] not compared) |
| discard | input | 1 | Empty the buffer without writes |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |
| inv_done | output | 1 | Invalidate command complete pulse |
| full | output | 1 | Buffer holds DEPTH entries |
| overflow | output | 1 | A cacheable record was dropped because the buffer was full |

## Verification
Two collisions need directed tests: a new record arriving in the same cycle as an invalidate removal, and a discard in the same cycle as a record or an invalidate. The bench drives both strobes in one cycle.

For the record/removal collision it checks the address that is written out, the overflow flag, and the order in which the remaining entries later drain. The buffer is tested both partly filled and full. For the discard collision it checks that the completion pulse arrives and that later invalidates find nothing.

// File: rtl/cbb_pkg.sv
package cbb_pkg;
  parameter int ADDR_W    = 32;
  parameter int DATA_W    = 32;
  parameter int LINE_BITS = 5;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cbb_entry_t;

  localparam logic [ADDR_W-1:0] LINE_OFS_MASK = ADDR_W'((1 << LINE_BITS) - 1);

  // Two addresses fall in the same line when they agree above the offset bits.
  function automatic logic same_line(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
    return ((a ^ b) & ~LINE_OFS_MASK) == '0;
  endfunction

  // Occupancy after one cycle of pushes, pops and clears.
  function automatic int unsigned next_count(input int unsigned cnt,
                                             input logic clr,
                                             input logic push,
                                             input logic pop);
    if (clr) return 0;
    return cnt + int'(push) - int'(pop);
  endfunction
endpackage

// File: rtl/cbb_slots.sv
module cbb_slots
  import cbb_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    push_i,
  input  cbb_entry_t              push_ent_i,
  input  logic                    pop_i,
  input  logic [IDX_W-1:0]        pop_idx_i,
  output cbb_entry_t [DEPTH-1:0]  ent_o,
  output logic [DEPTH-1:0]        vld_o,
  output logic [CNT_W-1:0]        cnt_o
);
  cbb_entry_t [DEPTH-1:0] ent_q, ent_d, ent_keep;
  logic [DEPTH-1:0]       vld_q, vld_d, vld_keep;
  logic [CNT_W-1:0]       cnt_q, cnt_d, tail;

  // After a removal the new entry goes right behind the survivors.
  assign tail  = cnt_q - CNT_W'(pop_i);
  assign cnt_d = CNT_W'(next_count(int'(cnt_q), clr_i, push_i, pop_i));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shift_in;
    assign shift_in = pop_i && (pop_idx_i <= IDX_W'(i));
    if (i == DEPTH - 1) begin : g_last
      assign ent_keep[i] = ent_q[i];
      assign vld_keep[i] = vld_q[i] && !shift_in;
    end else begin : g_mid
      assign ent_keep[i] = shift_in ? ent_q[i+1] : ent_q[i];
      assign vld_keep[i] = shift_in ? vld_q[i+1] : vld_q[i];
    end
    assign ent_d[i] = (push_i && tail == CNT_W'(i)) ? push_ent_i : ent_keep[i];
    assign vld_d[i] = !clr_i && ((push_i && tail == CNT_W'(i)) || vld_keep[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      ent_q <= ent_d;
      vld_q <= vld_d;
      cnt_q <= cnt_d;
    end
  end

  assign ent_o = ent_q;
  assign vld_o = vld_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/cbb_match.sv
module cbb_match
  import cbb_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_i,
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [ADDR_W-1:0]            key_i,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             idx_o
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec[i] = vld_i[i] && same_line(addr_i[i], key_i);
  end

  // Lowest index is the oldest entry, so it wins.
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/cbb_wb.sv
module cbb_wb
  import cbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  cbb_entry_t        load_ent_i,
  input  logic              miss_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o
);
  cbb_entry_t hold_q;
  logic       valid_q, done_q;
  logic       accept;

  assign accept = valid_q && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= miss_i || accept;
      if (load_i) begin
        hold_q  <= load_ent_i;
        valid_q <= 1'b1;
      end else if (accept) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = hold_q.addr;
  assign data_o  = hold_q.data;
  assign done_o  = done_q;
endmodule

// File: rtl/cas_backup_buf.sv
module cas_backup_buf
  import cbb_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_valid,
  input  logic [ADDR_W-1:0] rec_addr,
  input  logic [DATA_W-1:0] rec_data,
  input  logic              rec_cacheable,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              discard,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              inv_done,
  output logic              full,
  output logic              overflow
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  cbb_entry_t [DEPTH-1:0]      slot_ent;
  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0]            slot_vld;
  logic [CNT_W-1:0]            slot_cnt;
  logic                        hit;
  logic [IDX_W-1:0]            hit_idx;
  cbb_entry_t                  new_ent;
  logic                        overflow_q;

  // Named internal events, also observed by the bound checker.
  logic evt_take, evt_push, evt_drop, inv_take, evt_pop, evt_miss;

  assign full     = (slot_cnt == CNT_W'(DEPTH));
  assign evt_take = rec_valid && rec_cacheable && !discard;
  assign evt_push = evt_take && !full;
  assign evt_drop = evt_take && full;
  assign inv_take = inv_valid && !mem_wr_valid;
  assign evt_pop  = inv_take && hit && !discard;
  assign evt_miss = inv_take && !(hit && !discard);

  assign new_ent.addr = rec_addr;
  assign new_ent.data = rec_data;

  for (genvar i = 0; i < DEPTH; i++) begin : g_addr
    assign slot_addr[i] = slot_ent[i].addr;
  end

  cbb_slots #(.DEPTH(DEPTH)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (discard),
    .push_i     (evt_push),
    .push_ent_i (new_ent),
    .pop_i      (evt_pop),
    .pop_idx_i  (hit_idx),
    .ent_o      (slot_ent),
    .vld_o      (slot_vld),
    .cnt_o      (slot_cnt)
  );

  cbb_match #(.DEPTH(DEPTH)) u_match (
    .addr_i (slot_addr),
    .vld_i  (slot_vld),
    .key_i  (inv_addr),
    .hit_o  (hit),
    .idx_o  (hit_idx)
  );

  cbb_wb u_wb (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (evt_pop),
    .load_ent_i (slot_ent[hit_idx]),
    .miss_i     (evt_miss),
    .ready_i    (mem_wr_ready),
    .valid_o    (mem_wr_valid),
    .addr_o     (mem_wr_addr),
    .data_o     (mem_wr_data),
    .done_o     (inv_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow_q <= 1'b0;
    else        overflow_q <= evt_drop;
  end
  assign overflow = overflow_q;
endmodule

// File: rtl/cbb_chk.sv
module cbb_chk
  import cbb_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rec_valid,
  input logic              rec_cacheable,
  input logic              inv_valid,
  input logic              discard,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              inv_done,
  input logic              overflow,
  input logic [DEPTH-1:0]  slot_vld,
  input logic [CNT_W-1:0]  slot_cnt,
  input logic              evt_push,
  input logic              evt_drop,
  input logic              evt_pop,
  input logic              evt_miss
);
  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R8
  done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_ready |=> inv_done && !mem_wr_valid);

  // R7
  miss_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_miss |=> inv_done && !mem_wr_valid);

  // R10
  drop_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |=> overflow);

  // R9
  discard_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> (slot_cnt == '0) && !$rose(mem_wr_valid));

  // R6
  one_removal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pop |=> slot_cnt + CNT_W'(1) == $past(slot_cnt) + CNT_W'($past(evt_push)));

  // R12
  compact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_vld) == int'(slot_cnt));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && mem_wr_valid |-> !evt_pop && !evt_miss);

  // R2
  noncache_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_cacheable && !evt_pop && !discard |=> $stable(slot_cnt));
endmodule

bind cas_backup_buf cbb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rec_valid     (rec_valid),
  .rec_cacheable (rec_cacheable),
  .inv_valid     (inv_valid),
  .discard       (discard),
  .mem_wr_valid  (mem_wr_valid),
  .mem_wr_ready  (mem_wr_ready),
  .mem_wr_addr   (mem_wr_addr),
  .mem_wr_data   (mem_wr_data),
  .inv_done      (inv_done),
  .overflow      (overflow),
  .slot_vld      (slot_vld),
  .slot_cnt      (slot_cnt),
  .evt_push      (evt_push),
  .evt_drop      (evt_drop),
  .evt_pop       (evt_pop),
  .evt_miss      (evt_miss)
);

// File: tb/cas_backup_buf_test.sv
module cas_backup_buf_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rec_valid = 1'b0, rec_cacheable = 1'b0;
  logic [31:0] rec_addr = '0, rec_data = '0;
  logic        inv_valid = 1'b0;
  logic [31:0] inv_addr = '0;
  logic        discard = 1'b0;
  logic        mem_wr_valid, mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic        inv_done, full, overflow;

  always #5ns clk = ~clk;

  cas_backup_buf #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .rec_valid(rec_valid), .rec_addr(rec_addr), .rec_data(rec_data), .rec_cacheable(rec_cacheable),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .discard(discard),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .inv_done(inv_done), .full(full), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] qa[$];
  logic [31:0] qd[$];

  task automatic step();
    @(posedge clk);
    #1ns;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int find_line(input logic [31:0] a);
    foreach (qa[i]) if (qa[i][31:5] == a[31:5]) return i;
    return -1;
  endfunction

  task automatic rec(input logic [31:0] a, input logic [31:0] d, input bit c);
    bit was_full;
    was_full = (qa.size() == DEPTH);
    rec_valid = 1'b1; rec_addr = a; rec_data = d; rec_cacheable = c;
    step();
    rec_valid = 1'b0; rec_cacheable = 1'b0;
    if (c && !was_full) begin
      qa.push_back(a); qd.push_back(d);
    end
    chk(overflow == (c && was_full), "R10 overflow after record", overflow, c && was_full);
  endtask

  task automatic run_inv(input logic [31:0] a, input int hold, input bit with_rec,
                         input logic [31:0] ra, input logic [31:0] rd, input string tag);
    int h;
    int sz;
    logic [31:0] ea, ed;
    h  = find_line(a);
    sz = qa.size();
    inv_valid = 1'b1; inv_addr = a;
    if (with_rec) begin
      rec_valid = 1'b1; rec_addr = ra; rec_data = rd; rec_cacheable = 1'b1;
    end
    step();
    inv_valid = 1'b0; rec_valid = 1'b0; rec_cacheable = 1'b0;
    if (with_rec) chk(overflow == (sz == DEPTH), "R12 overflow on collision", overflow, sz == DEPTH);
    if (h < 0) begin
      if (with_rec && sz < DEPTH) begin qa.push_back(ra); qd.push_back(rd); end
      chk(mem_wr_valid == 1'b0, {tag, " miss has no write"}, mem_wr_valid, 0);
      chk(inv_done == 1'b1, "R7 done after miss", inv_done, 1);
      step();
      chk(inv_done == 1'b0, "R7 done is one pulse", inv_done, 0);
    end else begin
      ea = qa[h]; ed = qd[h];
      qa.delete(h); qd.delete(h);
      if (with_rec && sz < DEPTH) begin qa.push_back(ra); qd.push_back(rd); end
      chk(mem_wr_valid == 1'b1, "R5 write raised", mem_wr_valid, 1);
      chk(mem_wr_addr == ea, {tag, " write address"}, mem_wr_addr, ea);
      chk(mem_wr_data == ed, "R5 write data", mem_wr_data, ed);
      chk(inv_done == 1'b0, "R8 no early done", inv_done, 0);
      for (int k = 0; k < hold; k++) begin
        step();
        chk(mem_wr_valid && mem_wr_addr == ea && mem_wr_data == ed, "R5 held while not ready",
            {mem_wr_addr, mem_wr_data}, {ea, ed});
      end
      mem_wr_ready = 1'b1;
      step();
      mem_wr_ready = 1'b0;
      chk(mem_wr_valid == 1'b0, "R8 valid falls on accept", mem_wr_valid, 0);
      chk(inv_done == 1'b1, "R8 done after accept", inv_done, 1);
      step();
      chk(inv_done == 1'b0, "R8 done is one pulse", inv_done, 0);
    end
  endtask

  task automatic drain(input string tag);
    while (qa.size() > 0) run_inv(qa[0], 1, 1'b0, '0, '0, tag);
    chk(full == 1'b0, {tag, " empty after drain"}, full, 0);
  endtask

  task automatic t_reset();
    chk(full == 1'b0, "R1 full", full, 0);
    chk(mem_wr_valid == 1'b0, "R1 write valid", mem_wr_valid, 0);
    chk(inv_done == 1'b0, "R1 done", inv_done, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    run_inv(32'h0000_0100, 0, 1'b0, '0, '0, "R1");
  endtask

  task automatic t_order();
    rec(32'h1000_0000, 32'hA1, 1'b1);
    rec(32'h2000_0008, 32'hA2, 1'b1);
    rec(32'h3000_0010, 32'hA3, 1'b1);
    drain("R3");
  endtask

  task automatic t_noncache();
    rec(32'h4000_0000, 32'hB1, 1'b0);
    rec(32'h5000_0000, 32'hB2, 1'b1);
    run_inv(32'h4000_0000, 0, 1'b0, '0, '0, "R2");
    drain("R2");
  endtask

  task automatic t_lowbits();
    rec(32'h1000_0004, 32'hC1, 1'b1);
    run_inv(32'h1000_001C, 2, 1'b0, '0, '0, "R4");
    rec(32'h1000_0004, 32'hC2, 1'b1);
    run_inv(32'h1000_0020, 0, 1'b0, '0, '0, "R4");
    drain("R4");
  endtask

  task automatic t_multi();
    rec(32'h2000_0040, 32'hD1, 1'b1);
    rec(32'h3000_0000, 32'hD2, 1'b1);
    rec(32'h2000_0058, 32'hD3, 1'b1);
    run_inv(32'h2000_0044, 0, 1'b0, '0, '0, "R6");
    drain("R6");
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) rec(32'h6000_0000 + 32'(i * 32), 32'hE0 + 32'(i), 1'b1);
    chk(full == 1'b1, "R10 full at depth", full, 1);
    rec(32'h7000_0000, 32'hEF, 1'b1);
    step();
    chk(overflow == 1'b0, "R10 overflow is one pulse", overflow, 0);
    run_inv(32'h7000_0000, 0, 1'b0, '0, '0, "R10");
    drain("R10");
  endtask

  task automatic t_discard();
    rec(32'h8100_0000, 32'hF1, 1'b1);
    rec(32'h8200_0000, 32'hF2, 1'b1);
    discard = 1'b1;
    rec_valid = 1'b1; rec_addr = 32'h8000_0000; rec_data = 32'hF3; rec_cacheable = 1'b1;
    step();
    discard = 1'b0; rec_valid = 1'b0; rec_cacheable = 1'b0;
    qa.delete(); qd.delete();
    chk(mem_wr_valid == 1'b0, "R9 no write on discard", mem_wr_valid, 0);
    run_inv(32'h8000_0000, 0, 1'b0, '0, '0, "R9");
    run_inv(32'h8100_0000, 0, 1'b0, '0, '0, "R9");
    rec(32'h8300_0000, 32'hF4, 1'b1);
    discard = 1'b1; inv_valid = 1'b1; inv_addr = 32'h8300_0000;
    step();
    discard = 1'b0; inv_valid = 1'b0;
    qa.delete(); qd.delete();
    chk(inv_done == 1'b1, "R9 invalidate with discard completes", inv_done, 1);
    chk(mem_wr_valid == 1'b0, "R9 invalidate with discard writes nothing", mem_wr_valid, 0);
    step();
    run_inv(32'h8300_0000, 0, 1'b0, '0, '0, "R9");
  endtask

  task automatic t_busy();
    rec(32'h9000_0000, 32'h11, 1'b1);
    rec(32'h9000_0010, 32'h22, 1'b1);
    inv_valid = 1'b1; inv_addr = 32'h9000_0000;
    step();
    inv_valid = 1'b0;
    chk(mem_wr_addr == 32'h9000_0000, "R11 first write address", mem_wr_addr, 32'h9000_0000);
    inv_valid = 1'b1;
    step();
    inv_valid = 1'b0;
    chk(inv_done == 1'b0, "R11 ignored command gives no done", inv_done, 0);
    chk(mem_wr_addr == 32'h9000_0000, "R11 pending write unchanged", mem_wr_addr, 32'h9000_0000);
    mem_wr_ready = 1'b1;
    step();
    mem_wr_ready = 1'b0;
    chk(inv_done == 1'b1, "R11 done for first command", inv_done, 1);
    step();
    chk(inv_done == 1'b0, "R11 single done", inv_done, 0);
    qa.delete(0); qd.delete(0);
    drain("R11");
  endtask

  task automatic t_concurrent();
    rec(32'hA000_0000, 32'h31, 1'b1);
    rec(32'hA100_0000, 32'h32, 1'b1);
    run_inv(32'hA000_0000, 2, 1'b1, 32'hA200_0000, 32'h33, "R12");
    drain("R12");
    for (int i = 0; i < DEPTH; i++) rec(32'hB000_0000 + 32'(i * 64), 32'h40 + 32'(i), 1'b1);
    run_inv(32'hB000_0000, 0, 1'b1, 32'hBF00_0000, 32'h4F, "R12");
    drain("R12");
    run_inv(32'hBF00_0000, 0, 1'b0, '0, '0, "R12");
  endtask

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_order();
    t_noncache();
    t_lowbits();
    t_multi();
    t_full();
    t_discard();
    t_busy();
    t_concurrent();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000ns;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule